// File: doc/BRIEF.md
# Counter Latch and Byte-Sequenced Read Port

This block is one 16-bit down-counter channel with an 8-bit register port. Software chooses how the count is moved over the port: low byte only, high byte only, or low byte followed by high byte. That choice is made with a control-word write. The counting element decrements by one on each cycle where both the count enable and the gate are high.

An output latch normally follows the counting element. A latch command freezes it, so software can read a steady two-byte value while counting continues. The latch releases once the held value has been read in full in the chosen format, or when a new control word is written. Reads and writes have separate byte pointers, so software may interleave reads and writes of the same channel.

A read with no latch pending returns the live count. That value is only steady while the gate is low.

Top module: `cnt_latch_port`

## Requirements
- R1: Reset sets the count to 0000h and the format to low-then-high. It also clears any held latch and sets both byte pointers to the first (low) byte.
- R2: With gate and count enable both high and no count load, the count drops by one per clock and wraps from 0000h to FFFFh. If either input is low, the count holds.
- R3: Format codes are 01 (low byte only) and 10 (high byte only). A write in code 01 loads {00h, data}; a write in code 10 loads {data, 00h}. The load is visible on the following cycle.
- R4: Format code 11 is low-then-high. The first byte written does not change the count. The second byte loads {second, first}.
- R5: With no latch held, rdata shows a byte of the live count. Code 01 shows the low byte, code 10 shows the high byte, and code 11 shows low then high, following the read pointer. Reads in the single-byte codes do not advance any pointer.
- R6: A latch command captures the count present in that cycle. Reads then return the captured value while counting continues.
- R7: A latch command issued while a value is already held is ignored.
- R8: The latch releases after the last byte of the format has been read (one read for codes 01 and 10, two reads for code 11). After that, reads return the live count again.
- R9: The read pointer and write pointer advance independently. The sequence read low, write low, read high, write high returns the old count and loads the new one.
- R10: A control word with a nonzero code sets the format, resets both pointers to the low byte and releases any held latch. A data write in the same cycle is ignored.
- R11: A latch command does not change the programmed format.
- R12: A control word with code 00 is ignored. The format, both pointers and the latch are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable, qualified by gate |
| gate | input | 1 | Gate; counting is inhibited while low |
| cs | input | 1 | Channel select for rd and wr |
| rd | input | 1 | Read strobe; advances the read pointer at the clock edge |
| wr | input | 1 | Write strobe for wdata |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Selected byte of the held or live count |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_fmt | input | 2 | Format code: 01 low, 10 high, 11 low-then-high, 00 ignored |
| latch_cmd | input | 1 | Latch command strobe |
| count_live | output | 16 | Live value of the counting element |

## Verification
If the read pointer is out of step, every later two-byte read returns the bytes swapped. This appears on rdata at the very next read and stays until a control word resets the pointer. If the latch fails to release, or fails to stay held, the next read after counting returns a stale or drifting value. A write pointer out of step loads a count with mixed-up halves, which shows on count_live one cycle after the second write. A wrong wrap or gate qualification shows on count_live in the first cycle it applies.

// File: rtl/cnt_latch_port.sv
module cnt_latch_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_en,
  input  logic        gate,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        ctl_wr,
  input  logic [1:0]  ctl_fmt,
  input  logic        latch_cmd,
  output logic [15:0] count_live
);

  localparam logic [1:0] FMT_LO   = 2'b01;
  localparam logic [1:0] FMT_HI   = 2'b10;
  localparam logic [1:0] FMT_BOTH = 2'b11;

  logic [1:0]  fmt;
  logic        rptr, wptr, held;
  logic [15:0] ce, ol;
  logic [7:0]  wlo;

  wire ctl_ok   = ctl_wr && (ctl_fmt != 2'b00);
  wire rd_s     = cs && rd && !ctl_ok;
  wire wr_s     = cs && wr && !ctl_ok;
  wire rd_last  = (fmt != FMT_BOTH) || rptr;
  wire do_load  = wr_s && ((fmt != FMT_BOTH) || wptr);

  logic [15:0] load_val;
  always_comb begin
    case (fmt)
      FMT_LO:  load_val = {8'h00, wdata};
      FMT_HI:  load_val = {wdata, 8'h00};
      default: load_val = {wdata, wlo};
    endcase
  end

  wire [15:0] src     = held ? ol : ce;
  wire        pick_hi = (fmt == FMT_HI) || ((fmt == FMT_BOTH) && rptr);

  assign rdata      = pick_hi ? src[15:8] : src[7:0];
  assign count_live = ce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt  <= FMT_BOTH;
      rptr <= 1'b0;
      wptr <= 1'b0;
      held <= 1'b0;
      ol   <= 16'h0000;
      wlo  <= 8'h00;
    end else if (ctl_ok) begin
      fmt  <= ctl_fmt;
      rptr <= 1'b0;
      wptr <= 1'b0;
      held <= 1'b0;
    end else begin
      if (rd_s) begin
        if (fmt == FMT_BOTH) rptr <= ~rptr;
        if (rd_last) held <= 1'b0;
      end
      if (latch_cmd && !held) begin
        ol   <= ce;
        held <= 1'b1;
      end
      if (wr_s && fmt == FMT_BOTH) begin
        wptr <= ~wptr;
        if (!wptr) wlo <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ce <= 16'h0000;
    else if (do_load)        ce <= load_val;
    else if (gate && cnt_en) ce <= ce - 16'h0001;
  end

endmodule

// File: rtl/cnt_latch_port_chk.sv
module cnt_latch_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cnt_en,
  input logic        gate,
  input logic        cs,
  input logic        rd,
  input logic        wr,
  input logic [7:0]  wdata,
  input logic        ctl_wr,
  input logic [1:0]  ctl_fmt,
  input logic        latch_cmd,
  input logic [15:0] count_live,
  input logic [1:0]  fmt,
  input logic        rptr,
  input logic        wptr,
  input logic        held,
  input logic [15:0] ol
);
  wire ctl_ok = ctl_wr && (ctl_fmt != 2'b00);
  wire wr_s   = cs && wr && !ctl_ok;
  wire rd_fin = cs && rd && ((fmt != 2'b11) || rptr);

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && cnt_en && !wr_s && count_live == 16'h0000) |=> count_live == 16'hFFFF);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(gate && cnt_en) && !wr_s) |=> $stable(count_live));

  p_single_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && fmt == 2'b01) |=> count_live == {8'h00, $past(wdata)});

  p_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && fmt == 2'b11 && !wptr && !(gate && cnt_en)) |=> $stable(count_live));

  p_latch_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !ctl_ok && !rd_fin) |=> (held && $stable(ol)));

  p_ctl_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ok |=> (!held && !rptr && !wptr));

  p_fmt_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_cmd && !ctl_ok) |=> $stable(fmt));
endmodule

bind cnt_latch_port cnt_latch_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .cs(cs), .rd(rd),
  .wr(wr), .wdata(wdata), .ctl_wr(ctl_wr), .ctl_fmt(ctl_fmt),
  .latch_cmd(latch_cmd), .count_live(count_live), .fmt(fmt), .rptr(rptr),
  .wptr(wptr), .held(held), .ol(ol)
);

// File: tb/cnt_latch_port_tb.sv
module cnt_latch_port_tb;
  logic clk = 1'b0;
  logic rst_n, cnt_en, gate, cs, rd, wr, ctl_wr, latch_cmd;
  logic [7:0]  wdata;
  logic [1:0]  ctl_fmt;
  logic [7:0]  rdata;
  logic [15:0] count_live;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cnt_latch_port u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .cs(cs), .rd(rd),
    .wr(wr), .wdata(wdata), .rdata(rdata), .ctl_wr(ctl_wr), .ctl_fmt(ctl_fmt),
    .latch_cmd(latch_cmd), .count_live(count_live)
  );

  localparam logic [3:0] CHK = 4'd0, RD = 4'd1, WR = 4'd2, CTL = 4'd3,
                         LAT = 4'd4, TCK = 4'd5, STL = 4'd6;
  localparam int NV = 63;
  // {requirement number, op, value}
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, CHK, 16'h0000},  // R1
    {4'd1, RD,  16'h0000},  // R1
    {4'd1, RD,  16'h0000},  // R1
    {4'd4, WR,  16'h0034},
    {4'd4, CHK, 16'h0000},  // R4 partial
    {4'd4, WR,  16'h0012},
    {4'd4, CHK, 16'h1234},  // R4
    {4'd2, TCK, 16'h0000},
    {4'd2, TCK, 16'h0000},
    {4'd2, CHK, 16'h1232},  // R2
    {4'd6, LAT, 16'h0000},
    {4'd6, TCK, 16'h0000},
    {4'd6, TCK, 16'h0000},
    {4'd6, TCK, 16'h0000},
    {4'd6, CHK, 16'h122F},  // R6 counting goes on
    {4'd7, LAT, 16'h0000},  // R7 ignored
    {4'd6, RD,  16'h0032},  // R6
    {4'd7, TCK, 16'h0000},
    {4'd7, RD,  16'h0012},  // R7 first capture
    {4'd8, RD,  16'h002E},  // R8 live
    {4'd8, RD,  16'h0012},  // R8
    {4'd9, RD,  16'h002E},  // R9
    {4'd9, WR,  16'h0078},
    {4'd9, RD,  16'h0012},  // R9
    {4'd9, WR,  16'h0056},
    {4'd9, CHK, 16'h5678},  // R9
    {4'd5, RD,  16'h0078},  // R5
    {4'd5, RD,  16'h0056},  // R5
    {4'd10, LAT, 16'h0000},
    {4'd10, RD,  16'h0078},
    {4'd10, CTL, 16'h0001},
    {4'd10, TCK, 16'h0000},
    {4'd10, RD,  16'h0077},  // R10 latch dropped, pointer reset
    {4'd5,  RD,  16'h0077},  // R5 single byte
    {4'd3,  WR,  16'h00AB},
    {4'd3,  CHK, 16'h00AB},  // R3 low only
    {4'd3,  CTL, 16'h0002},
    {4'd3,  WR,  16'h00CD},
    {4'd3,  CHK, 16'hCD00},  // R3 high only
    {4'd5,  RD,  16'h00CD},  // R5
    {4'd11, LAT, 16'h0000},
    {4'd11, TCK, 16'h0000},
    {4'd11, RD,  16'h00CD},  // R11 still high-only
    {4'd8,  RD,  16'h00CC},  // R8 single read released
    {4'd2,  STL, 16'h0000},
    {4'd2,  CHK, 16'hCCFF},  // R2 enable low holds
    {4'd2,  CTL, 16'h0003},
    {4'd2,  WR,  16'h0000},
    {4'd2,  WR,  16'h0000},
    {4'd2,  CHK, 16'h0000},
    {4'd2,  TCK, 16'h0000},
    {4'd2,  CHK, 16'hFFFF},  // R2 wrap
    {4'd12, CTL, 16'h0000},
    {4'd12, WR,  16'h0001},
    {4'd12, CHK, 16'hFFFF},  // R12 still two-byte
    {4'd12, WR,  16'h0002},
    {4'd12, CHK, 16'h0201},  // R12
    {4'd10, WR,  16'h0099},
    {4'd10, CTL, 16'h0003},
    {4'd10, WR,  16'h0011},
    {4'd10, CHK, 16'h0201},  // R10 write pointer reset
    {4'd10, WR,  16'h0022},
    {4'd10, CHK, 16'h2211}   // R10
  };

  task automatic idle();
    cnt_en = 1'b1; gate = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0;
    ctl_wr = 1'b0; ctl_fmt = 2'b00; latch_cmd = 1'b0; wdata = 8'h00;
  endtask

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      case (VEC[i][19:16])
        RD:  begin cs = 1'b1; rd = 1'b1; end
        WR:  begin cs = 1'b1; wr = 1'b1; wdata = VEC[i][7:0]; end
        CTL: begin ctl_wr = 1'b1; ctl_fmt = VEC[i][1:0]; end
        LAT: latch_cmd = 1'b1;
        TCK: gate = 1'b1;
        STL: begin gate = 1'b1; cnt_en = 1'b0; end
        default: ;
      endcase
      #1;
      if (VEC[i][19:16] == RD)  check(int'(VEC[i][23:20]), {8'h00, rdata}, VEC[i]);
      if (VEC[i][19:16] == CHK) check(int'(VEC[i][23:20]), count_live, VEC[i][15:0]);
    end

    // R1: reset in the middle of a held latch and a half-written count
    @(negedge clk); idle(); latch_cmd = 1'b1;
    @(negedge clk); idle(); cs = 1'b1; wr = 1'b1; wdata = 8'h55;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1 check(1, count_live, 16'h0000);
    check(1, {8'h00, rdata}, 16'h0000);
    cs = 1'b1; wr = 1'b1; wdata = 8'h66;
    @(negedge clk); idle();
    #1 check(1, count_live, 16'h0000);  // R1 write pointer back at low byte
    cs = 1'b1; wr = 1'b1; wdata = 8'h77;
    @(negedge clk); idle();
    #1 check(1, count_live, 16'h7766);
    cs = 1'b1; rd = 1'b1;
    #1 check(5, {8'h00, rdata}, 16'h0066);  // R5 live low byte
    @(negedge clk); idle(); cs = 1'b1; rd = 1'b1;
    #1 check(5, {8'h00, rdata}, 16'h0077);  // R5 live high byte
    @(negedge clk); idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule